// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block watches three comparator flags that report the supply falling past three levels: an early-warning level, the minimum level at which the core may run, and the level at which the part switches to its backup cell. As the supply sinks, the block responds in three steps. First it raises a single maskable interrupt request that carries a fixed vector while the core keeps running. Next it holds the core in reset, pulls a shared open-drain reset line low and forces the bus strobes inactive. Last it drops an active-low battery-in-use flag.

The shared reset line works in both directions. Any module on the board may pull it low, and that also holds this block's core in reset, so a group of modules leaves and enters reset together. When every reset cause has cleared, the block keeps the core in reset for a fixed number of oscillator clocks before it lets go. Any new under-voltage or external pull during that window starts the count again. All asynchronous inputs pass through a two-flop synchronizer.

Top module: `pfs_supervisor`

## Requirements
- R1: While `rst_n` is low: `core_rst`=1, `strobe_block`=1, `irq_req`=0, `rstln_oe`=0 and `batt_n`=1. `irq_vector` always reads 8'h2B.
- R2: Suppose `warn_raw` rises while `warn_irq_en`=1 and the core is out of reset. Then `irq_req` is high for exactly one cycle, at the third rising clock edge after the input change.
- R3: A warning alone never asserts `core_rst`, `strobe_block` or `rstln_oe`.
- R4: Each rise of the warning flag gives at most one request. Holding the flag high gives none further, and setting `warn_irq_en` while the flag is already high gives none. The next request needs the flag to fall and rise again.
- R5: With `warn_irq_en`=0 at the rise, no request is made.
- R6: Within two clock edges of `vmin_raw` going high, `core_rst`, `strobe_block` and `rstln_oe` are all 1.
- R7: `batt_n` goes to 0 two edges after `vli_raw` rises. It returns to 1 two edges after `vli_raw` falls.
- R8: When `rstln_i` is pulled low by another module, `core_rst` is 1 within two edges. This block does not assert `rstln_oe` because of that pull.
- R9: After reset, `core_rst` falls on edge POR_CYCLES (21504 by default). After `vmin_raw` falls, it falls on edge POR_CYCLES+4, which includes the line resynchronization. After an external pull ends, it falls on edge POR_CYCLES+2.
- R10: If a reset cause returns during the delay, the count restarts in full once that cause ends.
- R11: No request is issued while `core_rst` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low initialisation |
| warn_raw | input | 1 | Supply below the warning level (async) |
| vmin_raw | input | 1 | Supply below the minimum running level (async) |
| vli_raw | input | 1 | Supply below the backup-switch level (async) |
| warn_irq_en | input | 1 | Enable for the warning interrupt |
| rstln_i | input | 1 | Sensed level of the shared reset line |
| rstln_oe | output | 1 | 1 pulls the shared reset line low |
| irq_req | output | 1 | One-cycle warning interrupt request |
| irq_vector | output | 8 | Vector address of the request (2Bh) |
| core_rst | output | 1 | Core reset, active high |
| strobe_block | output | 1 | Forces chip enables and R/W inactive |
| batt_n | output | 1 | 0 while running from the backup cell |

## Verification
Errors in the delay counter show up only at the final edge of a long reset window. For that reason the bench samples `core_rst` on the edge just before the expected release and on the release edge itself, for each of the three release paths and for a restarted count. An edge detector in the wrong state shows up within four cycles, either as a repeated request, a missing request or a request during reset. The bench therefore counts request pulses across each step instead of sampling one cycle. The flag paths are checked two edges after each input change, which is exactly the synchronizer depth.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   typedef struct packed {
      logic warn;
      logic vmin;
      logic vli;
      logic line_low;
   } pfs_flags_t;

   localparam int PFS_FLAG_N = $bits(pfs_flags_t);
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
   parameter int STAGES = 2,
   parameter int W      = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("pfs_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else if (s == 0) chain[s] <= d;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pfs_por_timer.sv
module pfs_por_timer #(
   parameter int POR_CYCLES = 21504
) (
   input  logic clk,
   input  logic rst_n,
   input  logic under,
   output logic busy
);
   localparam int CNT_W = (POR_CYCLES > 2) ? $clog2(POR_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(POR_CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   generate
      if (POR_CYCLES < 2) begin : g_bad
         $error("pfs_por_timer needs POR_CYCLES >= 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         busy <= 1'b1;
      end else if (under) begin
         cnt  <= '0;
         busy <= 1'b1;
      end else if (busy) begin
         if (cnt == LAST) busy <= 1'b0;
         else cnt <= cnt + 1'b1;
      end
   end

   // R10
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      under |=> (busy && cnt == '0));

   // R9
   por_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(cnt) == LAST));
endmodule

// File: rtl/pfs_warn_irq.sv
module pfs_warn_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic warn,
   input  logic en,
   input  logic hold,
   output logic irq
);
   logic warn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         warn_q <= 1'b0;
         irq    <= 1'b0;
      end else begin
         warn_q <= warn;
         irq    <= warn && !warn_q && en && !hold;
      end
   end

   // R2
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R11
   irq_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(!hold));
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
   import pfs_pkg::*;
#(
   parameter int          SYNC_STAGES = 2,
   parameter int          POR_CYCLES  = 21504,
   parameter int          VEC_W       = 8,
   parameter logic [7:0]  IRQ_VECTOR  = 8'h2B
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             warn_raw,
   input  logic             vmin_raw,
   input  logic             vli_raw,
   input  logic             warn_irq_en,
   input  logic             rstln_i,
   output logic             rstln_oe,
   output logic             irq_req,
   output logic [VEC_W-1:0] irq_vector,
   output logic             core_rst,
   output logic             strobe_block,
   output logic             batt_n
);
   pfs_flags_t flags_raw, flags_s;
   logic [PFS_FLAG_N-1:0] flags_s_bits;
   logic under, busy;

   assign flags_raw = '{warn: warn_raw, vmin: vmin_raw, vli: vli_raw, line_low: !rstln_i};

   pfs_sync #(.STAGES(SYNC_STAGES), .W(PFS_FLAG_N)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(flags_raw), .q(flags_s_bits)
   );
   assign flags_s = pfs_flags_t'(flags_s_bits);

   assign under = flags_s.vmin || flags_s.line_low;

   pfs_por_timer #(.POR_CYCLES(POR_CYCLES)) i_por (
      .clk(clk), .rst_n(rst_n), .under(under), .busy(busy)
   );

   assign core_rst     = under || busy;
   assign strobe_block = core_rst;
   assign rstln_oe     = flags_s.vmin;
   assign batt_n       = !flags_s.vli;
   assign irq_vector   = VEC_W'(IRQ_VECTOR);

   pfs_warn_irq i_irq (
      .clk(clk), .rst_n(rst_n), .warn(flags_s.warn), .en(warn_irq_en),
      .hold(core_rst), .irq(irq_req)
   );

   // R8
   line_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !core_rst |-> !flags_s.line_low);

   // R6
   vmin_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rstln_oe |-> core_rst);
endmodule

// File: tb/test_pfs_supervisor.sv
module test_pfs_supervisor;
   localparam int POR = 21504;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic warn_raw = 1'b0, vmin_raw = 1'b0, vli_raw = 1'b0, warn_irq_en = 1'b0;
   logic ext_pull = 1'b0;
   logic rstln_i, rstln_oe, irq_req, core_rst, strobe_block, batt_n;
   logic [7:0] irq_vector;
   int total = 0, bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   assign rstln_i = !(rstln_oe || ext_pull);

   pfs_supervisor #(.POR_CYCLES(POR)) i_pfs_supervisor (
      .clk(clk), .rst_n(rst_n), .warn_raw(warn_raw), .vmin_raw(vmin_raw),
      .vli_raw(vli_raw), .warn_irq_en(warn_irq_en), .rstln_i(rstln_i),
      .rstln_oe(rstln_oe), .irq_req(irq_req), .irq_vector(irq_vector),
      .core_rst(core_rst), .strobe_block(strobe_block), .batt_n(batt_n)
   );

   // fields: warn, en, vli | expected irq, batt_n, core_rst
   localparam logic [5:0] TBL [0:9] = '{
      6'b010_010, // R2 idle
      6'b110_110, // R2 R3 first crossing
      6'b110_010, // R4 held low, no repeat
      6'b010_010, // R4 back above
      6'b100_010, // R5 crossing while disabled
      6'b110_010, // R4 enabling while below
      6'b010_010, // R4 rearm
      6'b110_110, // R4 second crossing
      6'b011_000, // R7 backup flag
      6'b010_010  // R7 backup clear
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   initial begin
      int pulses;
      tick(3);
      chk("R1 core_rst", core_rst, 1);
      chk("R1 strobe_block", strobe_block, 1);
      chk("R1 irq_req", irq_req, 0);
      chk("R1 rstln_oe", rstln_oe, 0);
      chk("R1 batt_n", batt_n, 1);
      chk("R1 vector", irq_vector, 8'h2B);
      rst_n = 1'b1;
      tick(POR - 1);
      chk("R9 power-up hold", core_rst, 1);
      tick(1);
      chk("R9 power-up release", core_rst, 0);

      for (int i = 0; i < 10; i++) begin
         warn_raw = TBL[i][5]; warn_irq_en = TBL[i][4]; vli_raw = TBL[i][3];
         pulses = 0;
         for (int c = 0; c < 4; c++) begin
            tick(1);
            if (c == 1) chk("R7 batt_n", batt_n, TBL[i][1]);
            if (c == 2) chk("R2 irq at third edge", irq_req, TBL[i][2]);
            if (irq_req) pulses++;
         end
         chk("R4 pulse count", pulses, TBL[i][2]);
         chk("R3 core_rst", core_rst | strobe_block | rstln_oe, TBL[i][0]);
      end

      // under-voltage with warning and backup during reset
      warn_raw = 1'b0; warn_irq_en = 1'b1;
      tick(4);
      vmin_raw = 1'b1;
      tick(2);
      chk("R6 core_rst", core_rst, 1);
      chk("R6 strobe_block", strobe_block, 1);
      chk("R6 rstln_oe", rstln_oe, 1);
      warn_raw = 1'b1;
      pulses = 0;
      for (int c = 0; c < 5; c++) begin tick(1); if (irq_req) pulses++; end
      chk("R11 no irq in reset", pulses, 0);
      vli_raw = 1'b1;
      tick(2);
      chk("R7 batt_n low", batt_n, 0);
      vli_raw = 1'b0; warn_raw = 1'b0;
      tick(3);
      vmin_raw = 1'b0;
      tick(2);
      chk("R6 line released", rstln_oe, 0);
      tick(POR + 4 - 2 - 1);
      chk("R9 vmin hold", core_rst, 1);
      tick(1);
      chk("R9 vmin release", core_rst, 0);

      // external pull on the shared line
      ext_pull = 1'b1;
      tick(2);
      chk("R8 core_rst", core_rst, 1);
      chk("R8 no own drive", rstln_oe, 0);
      tick(3);
      ext_pull = 1'b0;
      tick(POR + 2 - 1);
      chk("R9 ext hold", core_rst, 1);
      tick(1);
      chk("R9 ext release", core_rst, 0);

      // restart during the delay
      vmin_raw = 1'b1;
      tick(3);
      vmin_raw = 1'b0;
      tick(1000);
      vmin_raw = 1'b1;
      tick(5);
      vmin_raw = 1'b0;
      tick(POR + 4 - 1);
      chk("R10 restart hold", core_rst, 1);
      tick(1);
      chk("R10 restart release", core_rst, 0);

      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule